// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block follows a CAN node from the moment its error logic declares it bus-off until it is allowed to take part in traffic again. While the node is bus-off, the block watches the received bit stream, one sample per strobe, and counts runs of consecutive recessive bits. Normal recovery ends after a fixed number of such runs. When recovery ends, the block drops the bus-off status and sends a one-cycle pulse that resets the transmit and receive error counters.

Software can hold the node off the bus with a recovery-hold control. The block reads that control only on the cycle it enters bus-off, and the value it reads governs that one bus-off episode. When software releases a hold, the outcome depends on how far recovery has got. If the run count has not reached its target, recovery carries on from where it stood. If the target has already been reached, the node first waits for one more recessive run to resynchronise. A sticky interrupt flag records each bus-off entry. Software clears the flag by writing one to it. A mask decides whether the flag raises the interrupt request.

Top module: `busoff_recovery_ctrl`

## Requirements
- R1: After reset, `busoff`, `boff_flag`, `irq` and `err_cnt_clr` are all 0, and both internal counts start from zero.
- R2: A `enter_pulse` while not bus-off sets `busoff` to 1 on the following clock edge. A `enter_pulse` while already bus-off is ignored and does not restart the recovery in progress.
- R3: Without a hold, `busoff` falls one cycle after the strobe that completes the SEQ_TARGET-th run (default 128) of RUN_LEN (default 11) consecutive recessive samples. A sample is a cycle with `bit_strobe`=1, and `bit_rx`=1 means recessive.
- R4: A dominant sample (`bit_rx`=0) restarts the current recessive run from zero. It keeps the number of runs already completed.
- R5: If `hold_ctrl` is 1 on the entry cycle, the node stays bus-off for as long as `hold_ctrl` stays 1, whatever the samples are. The count of completed runs saturates at SEQ_TARGET during the hold.
- R6: If `hold_ctrl` is released before SEQ_TARGET runs have completed, recovery continues from the runs already counted, exactly as in R3.
- R7: If `hold_ctrl` is released after SEQ_TARGET runs have completed, the block waits for one more run of RUN_LEN recessive samples, counted from the release. `busoff` falls on the edge that takes the last sample of that run.
- R8: Setting `hold_ctrl` during a bus-off whose entry saw it at 0 has no effect on that recovery.
- R9: `err_cnt_clr` is 1 for exactly one cycle, the first cycle in which `busoff` is 0 after a bus-off.
- R10: `boff_flag` becomes 1 on bus-off entry. A write (`flag_wr`=1) with `flag_wdata`=1 clears it. A write with `flag_wdata`=0 leaves it unchanged.
- R11: When an entry and a write-one-to-clear occur in the same cycle, the flag ends up set.
- R12: `irq` is a register that, one edge later, takes the value the flag is being given AND `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_pulse | input | 1 | Bus-off entry request from the error-count logic |
| bit_strobe | input | 1 | One-cycle strobe marking a bus sample |
| bit_rx | input | 1 | Sampled bus level, 1 = recessive |
| hold_ctrl | input | 1 | Software recovery-hold control |
| irq_mask | input | 1 | Interrupt enable for the bus-off flag |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| busoff | output | 1 | Node is bus-off |
| boff_flag | output | 1 | Sticky bus-off entry flag |
| irq | output | 1 | Interrupt request |
| err_cnt_clr | output | 1 | One-cycle request to reset the error counters |

## Verification
Some properties are checked by assertions on every cycle: the run and run-count limits, the restart on a dominant sample, staying bus-off under a hold, entry requests being ignored during auto recovery, the clear pulse lining up with the fall of `busoff`, set winning over clear, and the masking of `irq`. Other behaviour needs the bench's scenarios, because it only appears across long stretches of samples. This covers recovery on exactly the right sample, the two release paths (continuing the count or resynchronising), the hold control being ignored when it is set after entry, and a dominant sample placed near the end of recovery.

// File: rtl/busoff_pkg.sv
package busoff_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_AUTO   = 2'd1,
    ST_HELD   = 2'd2,
    ST_RESYNC = 2'd3
  } bo_state_e;
endpackage

// File: rtl/bo_run_counter.sv
module bo_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  input  logic strobe,
  input  logic bit_rx,
  output logic run_done
);
  localparam int W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last  = (cnt_q == W'(RUN_LEN - 1));
  assign run_done = enable && !clear && strobe && bit_rx && at_last;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (enable && strobe) begin
      if (!bit_rx || at_last) cnt_q <= '0;
      else                    cnt_q <= cnt_q + W'(1);
    end
  end

  a_r3_run_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(RUN_LEN - 1));

  a_r4_dominant_restart: assert property (@(posedge clk) disable iff (rst)
    (enable && strobe && !bit_rx && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/bo_seq_counter.sv
module bo_seq_counter #(
  parameter int SEQ_TARGET = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic full
);
  localparam int W = $clog2(SEQ_TARGET + 1);

  logic [W-1:0] cnt_q;

  assign full = (cnt_q == W'(SEQ_TARGET));

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt_q <= '0;
    else if (inc && !full) cnt_q <= cnt_q + W'(1);
  end

  a_r5_seq_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(SEQ_TARGET));

  a_r4_seq_kept: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/bo_flag_unit.sv
module bo_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_data,
  input  logic mask,
  output logic flag,
  output logic irq
);
  logic flag_q, irq_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_evt)               flag_d = 1'b1;
    else if (wr_en && wr_data) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & mask;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q);

  a_r10_write_zero: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_en && !wr_data) |=> flag_q);

  a_r12_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !irq_q);
endmodule

// File: rtl/bo_recovery_fsm.sv
module bo_recovery_fsm
  import busoff_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enter_pulse,
  input  logic hold_ctrl,
  input  logic run_done,
  input  logic seq_full,
  output logic busoff,
  output logic counting,
  output logic run_clr,
  output logic seq_clr,
  output logic seq_inc,
  output logic flag_set,
  output logic cnt_clr_pulse
);
  bo_state_e state_q, state_d;
  logic      clr_q, exit_now;

  always_comb begin
    state_d  = state_q;
    run_clr  = 1'b0;
    seq_clr  = 1'b0;
    flag_set = 1'b0;
    exit_now = 1'b0;
    unique case (state_q)
      ST_ACTIVE: if (enter_pulse) begin
        state_d  = hold_ctrl ? ST_HELD : ST_AUTO;
        run_clr  = 1'b1;
        seq_clr  = 1'b1;
        flag_set = 1'b1;
      end
      ST_AUTO: if (seq_full) begin
        state_d  = ST_ACTIVE;
        exit_now = 1'b1;
      end
      ST_HELD: if (!hold_ctrl) begin
        if (seq_full) begin
          state_d = ST_RESYNC;
          run_clr = 1'b1;
        end else begin
          state_d = ST_AUTO;
        end
      end
      ST_RESYNC: if (run_done) begin
        state_d  = ST_ACTIVE;
        exit_now = 1'b1;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACTIVE;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= exit_now;
    end
  end

  assign busoff        = (state_q != ST_ACTIVE);
  assign counting      = busoff;
  assign seq_inc       = run_done && (state_q == ST_AUTO || state_q == ST_HELD);
  assign cnt_clr_pulse = clr_q;

  a_r9_clr_with_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(busoff) |-> clr_q);

  a_r9_clr_single: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q);

  a_r5_hold_stays: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HELD && hold_ctrl) |=> busoff);

  a_r2_enter_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AUTO && !seq_full && enter_pulse) |=> (state_q == ST_AUTO));
endmodule

// File: rtl/busoff_recovery_ctrl.sv
module busoff_recovery_ctrl #(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic enter_pulse,
  input  logic bit_strobe,
  input  logic bit_rx,
  input  logic hold_ctrl,
  input  logic irq_mask,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic busoff,
  output logic boff_flag,
  output logic irq,
  output logic err_cnt_clr
);
  logic run_done, seq_full, counting, run_clr, seq_clr, seq_inc, flag_set;

  bo_recovery_fsm u_fsm (
    .clk(clk), .rst(rst), .enter_pulse(enter_pulse), .hold_ctrl(hold_ctrl),
    .run_done(run_done), .seq_full(seq_full), .busoff(busoff),
    .counting(counting), .run_clr(run_clr), .seq_clr(seq_clr),
    .seq_inc(seq_inc), .flag_set(flag_set), .cnt_clr_pulse(err_cnt_clr)
  );

  bo_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .clear(run_clr), .enable(counting),
    .strobe(bit_strobe), .bit_rx(bit_rx), .run_done(run_done)
  );

  bo_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk(clk), .rst(rst), .clear(seq_clr), .inc(seq_inc), .full(seq_full)
  );

  bo_flag_unit u_flag (
    .clk(clk), .rst(rst), .set_evt(flag_set), .wr_en(flag_wr),
    .wr_data(flag_wdata), .mask(irq_mask), .flag(boff_flag), .irq(irq)
  );
endmodule

// File: tb/tb_busoff_recovery_ctrl.sv
module tb_busoff_recovery_ctrl;
  localparam int RUN = 11;
  localparam int SEQ = 128;
  localparam int FULL = RUN * SEQ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter_pulse = 0, bit_strobe = 0, bit_rx = 1, hold_ctrl = 0;
  logic irq_mask = 0, flag_wr = 0, flag_wdata = 0;
  logic busoff, boff_flag, irq, err_cnt_clr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    logic  bo, fl, iq, cl;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  busoff_recovery_ctrl dut (
    .clk(clk), .rst(rst), .enter_pulse(enter_pulse), .bit_strobe(bit_strobe),
    .bit_rx(bit_rx), .hold_ctrl(hold_ctrl), .irq_mask(irq_mask),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .busoff(busoff),
    .boff_flag(boff_flag), .irq(irq), .err_cnt_clr(err_cnt_clr)
  );

  // Monitor: compares the queued expectations with the outputs between edges
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if ({busoff, boff_flag, irq, err_cnt_clr} !== {e.bo, e.fl, e.iq, e.cl}) begin
        bad++;
        $display("FAIL %s: busoff/flag/irq/clr actual=%b%b%b%b expected=%b%b%b%b",
                 e.tag, busoff, boff_flag, irq, err_cnt_clr, e.bo, e.fl, e.iq, e.cl);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic expect_out(string tag, logic bo, logic fl, logic iq, logic cl);
    exp_t e;
    e.tag = tag; e.bo = bo; e.fl = fl; e.iq = iq; e.cl = cl;
    q.push_back(e);
  endtask

  task automatic send_bits(int n, logic v);
    for (int i = 0; i < n; i++) begin
      bit_strobe = 1'b1; bit_rx = v;
      tick();
    end
    bit_strobe = 1'b0; bit_rx = 1'b1;
  endtask

  task automatic enter_busoff();
    enter_pulse = 1'b1;
    tick();
    enter_pulse = 1'b0;
  endtask

  task automatic clear_flag();
    flag_wr = 1'b1; flag_wdata = 1'b1;
    tick();
    flag_wr = 1'b0; flag_wdata = 1'b0;
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    expect_out("R1", 0, 0, 0, 0);

    // Auto recovery; hold set after entry is ignored; re-entry ignored
    irq_mask = 1'b1;
    enter_busoff();
    expect_out("R2", 1, 1, 1, 0);
    flag_wr = 1'b1; flag_wdata = 1'b0; tick(); flag_wr = 1'b0;
    expect_out("R10", 1, 1, 1, 0);
    hold_ctrl = 1'b1;                       // R8
    send_bits(700, 1'b1);
    enter_busoff();                         // R2 ignored
    send_bits(FULL - 700 - 1, 1'b1);
    expect_out("R3", 1, 1, 1, 0);
    send_bits(1, 1'b1);
    expect_out("R8", 1, 1, 1, 0);
    tick();
    expect_out("R3", 0, 1, 1, 1);
    tick();
    expect_out("R9", 0, 1, 1, 0);
    hold_ctrl = 1'b0;
    clear_flag();
    expect_out("R10", 0, 0, 0, 0);

    // Dominant sample near the end restarts the run only
    irq_mask = 1'b0;
    enter_busoff();
    expect_out("R12", 1, 1, 0, 0);
    send_bits(FULL - 1, 1'b1);
    send_bits(1, 1'b0);
    send_bits(RUN - 1, 1'b1);
    tick();
    expect_out("R4", 1, 1, 0, 0);
    send_bits(1, 1'b1);
    tick();
    expect_out("R4", 0, 1, 0, 1);
    irq_mask = 1'b1;
    tick();
    expect_out("R12", 0, 1, 1, 0);
    clear_flag();
    expect_out("R10", 0, 0, 0, 0);

    // Held entry with simultaneous clear; late release needs resync run
    hold_ctrl = 1'b1;
    flag_wr = 1'b1; flag_wdata = 1'b1;
    enter_busoff();
    flag_wr = 1'b0; flag_wdata = 1'b0;
    expect_out("R11", 1, 1, 1, 0);
    send_bits(FULL + 50, 1'b1);
    tick();
    expect_out("R5", 1, 1, 1, 0);
    hold_ctrl = 1'b0;
    tick();
    expect_out("R7", 1, 1, 1, 0);
    send_bits(RUN - 1, 1'b1);
    expect_out("R7", 1, 1, 1, 0);
    send_bits(1, 1'b1);
    expect_out("R7", 0, 1, 1, 1);
    tick();
    expect_out("R9", 0, 1, 1, 0);
    clear_flag();

    // Held entry, early release continues the count
    hold_ctrl = 1'b1;
    enter_busoff();
    send_bits(50 * RUN, 1'b1);
    expect_out("R5", 1, 1, 1, 0);
    hold_ctrl = 1'b0;
    tick();
    send_bits(FULL - 50 * RUN, 1'b1);
    expect_out("R6", 1, 1, 1, 0);
    tick();
    expect_out("R6", 0, 1, 1, 1);
    tick();
    expect_out("R9", 0, 1, 1, 0);

    tick(); tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule